// File: doc/BRIEF.md
# Borrow-Subtract and Exclusive-OR Flag Unit

This unit is the arithmetic slice of an 8-bit processor core that handles two instruction groups: subtract with borrow and exclusive-OR, both acting on the accumulator. It takes the opcode, the current accumulator, the current carry flag and the six general registers. When the opcode names memory or an immediate byte as its source, it asks for that byte on the operand input. It returns the new accumulator value and a status byte that holds the zero, subtract, half-carry and carry flags.

The caller presents an opcode with `op_valid`. An opcode whose operand is a register, or the accumulator, gives its result on the next clock. An opcode whose operand comes from memory or from an immediate byte first raises `opnd_req` for one cycle. During that cycle the caller places the byte on `opnd_data`, and the result follows on the next clock. An opcode outside the two groups is dropped.

Top module: `sbcx_alu`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `res_valid`, `opnd_req`, `res_acc` and `res_flags` are all zero.
- R2: For subtract with borrow, the new accumulator is (A - operand - carry_in) modulo 256.
- R3: For subtract with borrow, the carry flag is set when A - operand - carry_in is below zero, i.e. either the operand subtraction or the following carry-in subtraction borrows.
- R4: For subtract with borrow, the half-carry flag is set when (A mod 16) - (operand mod 16) - carry_in is below zero.
- R5: For subtract with borrow, the subtract flag is set, and for both groups the zero flag is set exactly when the new accumulator is 0x00.
- R6: For exclusive-OR, the new accumulator is A XOR operand, the zero flag follows the result, and the subtract, half-carry and carry flags are clear.
- R7: Opcodes 0x98..0x9F select subtract with borrow and 0xA8..0xAF select exclusive-OR. Opcode bits 2:0 pick the operand as 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory byte at HL (from `opnd_data`), 7 A. Register i sits at `gpr[8*i+7:8*i]`, with B as i=0 and L as i=5.
- R8: Opcode 0xDE is subtract with borrow and 0xEE is exclusive-OR, both with an immediate byte. When one is accepted, `opnd_req` and `opnd_imm` are high in the next cycle. The result uses the `opnd_data` of that cycle and appears one cycle after it.
- R9: An accepted memory-source form (bits 2:0 = 6) raises `opnd_req` with `opnd_imm` low for exactly one cycle. The result follows in the next cycle, and no result is given while `opnd_req` is high.
- R10: `res_flags` holds zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3:0 are always zero.
- R11: `op_valid` is ignored while `opnd_req` is high, and A and carry_in are the values present when the opcode was accepted.
- R12: Any other opcode produces neither `res_valid` nor `opnd_req`.
- R13: A register-source form accepted in a cycle gives `res_valid` with its result on the next cycle. Back-to-back register forms give a result every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode presented this cycle |
| op_code | input | 8 | Opcode byte |
| acc_in | input | 8 | Current accumulator |
| cy_in | input | 1 | Current carry flag |
| gpr | input | 48 | Registers B, C, D, E, H, L, one byte each, B lowest |
| opnd_data | input | 8 | Memory or immediate operand byte, used while opnd_req is high |
| opnd_req | output | 1 | Operand byte wanted on opnd_data this cycle |
| opnd_imm | output | 1 | The wanted byte is the immediate, not the memory byte at HL |
| res_valid | output | 1 | res_acc and res_flags carry a new result |
| res_acc | output | 8 | New accumulator value |
| res_flags | output | 8 | New status byte |

## Verification
Two things can meet in one cycle: the completion of a two-cycle form and the arrival of another opcode on `op_valid`. The bench provokes this by holding `op_valid` high for two cycles on memory and immediate forms, and by changing `acc_in` and `cy_in` in the waiting cycle. The behavioural model expects exactly one result, computed from the A and carry captured when the opcode was accepted, and no result for the held opcode. Back-to-back register forms also test that a result is produced on every cycle.

// File: rtl/sbcx_pkg.sv
package sbcx_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int GPR_N    = 6;
    localparam int SEL_W    = 3;
    localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;
    localparam logic [SEL_W-1:0] SEL_ACC = 3'd7;

    typedef enum logic [1:0] {K_NONE, K_SBC, K_XOR} op_kind_e;
    typedef enum logic [1:0] {SRC_REG, SRC_MEM, SRC_IMM} src_e;

    typedef struct packed {
        op_kind_e         kind;
        src_e             src;
        logic [SEL_W-1:0] sel;
    } dec_s;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_s;

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        flags_s            fl;
    } res_s;

    function automatic logic [BYTE_W-1:0] pack_flags(flags_s f);
        return {f.z, f.n, f.h, f.c, {(BYTE_W-4){1'b0}}};
    endfunction

    function automatic res_s do_sbc(logic [BYTE_W-1:0] a, logic [BYTE_W-1:0] b, logic cin);
        logic [BYTE_W:0] full;
        logic [NIB_W:0]  low;
        res_s            r;
        full = {1'b0, a} - {1'b0, b} - {{BYTE_W{1'b0}}, cin};
        low  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
        r.acc  = full[BYTE_W-1:0];
        r.fl.z = (full[BYTE_W-1:0] == '0);
        r.fl.n = 1'b1;
        r.fl.h = low[NIB_W];
        r.fl.c = full[BYTE_W];
        return r;
    endfunction

    function automatic res_s do_xor(logic [BYTE_W-1:0] a, logic [BYTE_W-1:0] b);
        res_s r;
        r.acc  = a ^ b;
        r.fl.z = ((a ^ b) == '0);
        r.fl.n = 1'b0;
        r.fl.h = 1'b0;
        r.fl.c = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sbcx_decode.sv
module sbcx_decode
    import sbcx_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output dec_s              dec
);
    localparam logic [4:0]        GRP_SBC = 5'b10011;
    localparam logic [4:0]        GRP_XOR = 5'b10101;
    localparam logic [BYTE_W-1:0] IMM_SBC = 8'hDE;
    localparam logic [BYTE_W-1:0] IMM_XOR = 8'hEE;

    always_comb begin
        dec.kind = K_NONE;
        dec.src  = SRC_REG;
        dec.sel  = opcode[SEL_W-1:0];
        if (opcode[BYTE_W-1:SEL_W] == GRP_SBC) begin
            dec.kind = K_SBC;
        end else if (opcode[BYTE_W-1:SEL_W] == GRP_XOR) begin
            dec.kind = K_XOR;
        end else if (opcode == IMM_SBC) begin
            dec.kind = K_SBC;
        end else if (opcode == IMM_XOR) begin
            dec.kind = K_XOR;
        end
        if (opcode == IMM_SBC || opcode == IMM_XOR) begin
            dec.src = SRC_IMM;
        end else if (dec.kind != K_NONE && opcode[SEL_W-1:0] == SEL_MEM) begin
            dec.src = SRC_MEM;
        end
    end
endmodule

// File: rtl/sbcx_exec.sv
module sbcx_exec
    import sbcx_pkg::*;
(
    input  op_kind_e          kind,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              cin,
    output res_s              res
);
    always_comb begin
        unique case (kind)
            K_SBC:   res = do_sbc(a, b, cin);
            K_XOR:   res = do_xor(a, b);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/sbcx_alu.sv
module sbcx_alu
    import sbcx_pkg::*;
#(
    parameter int NUM_GPR = GPR_N
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      op_valid,
    input  logic [BYTE_W-1:0]         op_code,
    input  logic [BYTE_W-1:0]         acc_in,
    input  logic                      cy_in,
    input  logic [NUM_GPR*BYTE_W-1:0] gpr,
    input  logic [BYTE_W-1:0]         opnd_data,
    output logic                      opnd_req,
    output logic                      opnd_imm,
    output logic                      res_valid,
    output logic [BYTE_W-1:0]         res_acc,
    output logic [BYTE_W-1:0]         res_flags
);
    dec_s              dec_now;
    dec_s              dec_q;
    logic              pend_q;
    logic [BYTE_W-1:0] a_q;
    logic              cy_q;
    logic              rv_q;
    res_s              res_q;

    op_kind_e          x_kind;
    logic [BYTE_W-1:0] x_a;
    logic [BYTE_W-1:0] x_b;
    logic              x_cin;
    res_s              x_res;
    logic              accept;

    sbcx_decode u_dec (.opcode(op_code), .dec(dec_now));

    assign accept = op_valid && !pend_q && (dec_now.kind != K_NONE);

    always_comb begin
        if (pend_q) begin
            x_kind = dec_q.kind;
            x_a    = a_q;
            x_cin  = cy_q;
            x_b    = opnd_data;
        end else begin
            x_kind = dec_now.kind;
            x_a    = acc_in;
            x_cin  = cy_in;
            if (dec_now.sel == SEL_ACC) begin
                x_b = acc_in;
            end else if (int'(dec_now.sel) < NUM_GPR) begin
                x_b = gpr[int'(dec_now.sel)*BYTE_W +: BYTE_W];
            end else begin
                x_b = '0;
            end
        end
    end

    sbcx_exec u_exec (.kind(x_kind), .a(x_a), .b(x_b), .cin(x_cin), .res(x_res));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            dec_q  <= '0;
            a_q    <= '0;
            cy_q   <= 1'b0;
            rv_q   <= 1'b0;
            res_q  <= '0;
        end else begin
            rv_q <= 1'b0;
            if (pend_q) begin
                pend_q <= 1'b0;
                rv_q   <= 1'b1;
                res_q  <= x_res;
            end else if (accept) begin
                if (dec_now.src == SRC_REG) begin
                    rv_q  <= 1'b1;
                    res_q <= x_res;
                end else begin
                    pend_q <= 1'b1;
                    dec_q  <= dec_now;
                    a_q    <= acc_in;
                    cy_q   <= cy_in;
                end
            end
        end
    end

    assign opnd_req  = pend_q;
    assign opnd_imm  = pend_q && (dec_q.src == SRC_IMM);
    assign res_valid = rv_q;
    assign res_acc   = res_q.acc;
    assign res_flags = pack_flags(res_q.fl);

    a_r13_reg_form_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !opnd_req && dec_now.kind != K_NONE && dec_now.src == SRC_REG) |=> res_valid);

    a_r9_wait_form_requests: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !opnd_req && dec_now.kind != K_NONE && dec_now.src != SRC_REG)
        |=> (opnd_req && !res_valid));

    a_r8_single_wait_cycle: assert property (@(posedge clk) disable iff (rst)
        opnd_req |=> (!opnd_req && res_valid));

    a_r12_unknown_dropped: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !opnd_req && dec_now.kind == K_NONE) |=> (!res_valid && !opnd_req));

    a_r5_zero_tracks_acc: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_flags[7] == (res_acc == '0)));

    a_r10_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_flags[3:0] == 4'h0));

endmodule

// File: tb/test_sbcx_alu.sv
module test_sbcx_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [7:0]  acc_in = 8'h00;
    logic        cy_in = 1'b0;
    logic [7:0]  g [0:5];
    logic [47:0] gpr;
    logic [7:0]  opnd_data = 8'h00;
    logic        opnd_req, opnd_imm, res_valid;
    logic [7:0]  res_acc, res_flags;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // model state
    bit       m_pend = 0;
    int       m_kind = 0;
    bit       m_imm = 0;
    int       m_a = 0;
    int       m_cy = 0;
    bit       e_valid = 0;
    bit       e_req = 0;
    bit       e_imm = 0;
    int       e_acc = 0;
    int       e_fl = 0;

    assign gpr = {g[5], g[4], g[3], g[2], g[1], g[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    sbcx_alu i_sbcx_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .cy_in(cy_in), .gpr(gpr), .opnd_data(opnd_data),
        .opnd_req(opnd_req), .opnd_imm(opnd_imm), .res_valid(res_valid),
        .res_acc(res_acc), .res_flags(res_flags)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural result: returns {acc, flagbyte}
    function automatic int calc(int kind, int a, int b, int cy);
        int r, z, n, h, c;
        if (kind == 1) begin
            r = a - b - cy;
            c = (r < 0) ? 1 : 0;
            h = (((a % 16) - (b % 16) - cy) < 0) ? 1 : 0;
            n = 1;
            r = (r + 512) % 256;
        end else begin
            r = a ^ b;
            n = 0; h = 0; c = 0;
        end
        z = (r == 0) ? 1 : 0;
        return r * 256 + z * 128 + n * 64 + h * 32 + c * 16;
    endfunction

    always @(posedge clk) begin
        int kind, idx, b, v;
        bit two;
        if (rst) begin
            m_pend = 0; e_valid = 0; e_req = 0; e_imm = 0; e_acc = 0; e_fl = 0;
        end else begin
            e_valid = 0;
            if (m_pend) begin
                v = calc(m_kind, m_a, int'(opnd_data), m_cy);
                e_valid = 1; e_acc = v / 256; e_fl = v % 256;
                m_pend = 0;
            end else if (op_valid) begin
                kind = 0; two = 0; m_imm = 0;
                idx = int'(op_code) % 8;
                if (op_code >= 8'h98 && op_code <= 8'h9F) kind = 1;
                if (op_code >= 8'hA8 && op_code <= 8'hAF) kind = 2;
                if (kind != 0 && idx == 6) two = 1;
                if (op_code == 8'hDE) begin kind = 1; two = 1; m_imm = 1; end
                if (op_code == 8'hEE) begin kind = 2; two = 1; m_imm = 1; end
                if (kind != 0) begin
                    if (two) begin
                        m_pend = 1; m_kind = kind; m_a = int'(acc_in); m_cy = int'(cy_in);
                    end else begin
                        b = (idx == 7) ? int'(acc_in) : int'(g[idx]);
                        v = calc(kind, int'(acc_in), b, int'(cy_in));
                        e_valid = 1; e_acc = v / 256; e_fl = v % 256;
                    end
                end
            end
            e_req = m_pend;
            e_imm = m_pend && m_imm;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check({cur_tag, " res_valid"}, int'(res_valid), int'(e_valid));
            check({cur_tag, " opnd_req"}, int'(opnd_req), int'(e_req));
            if (e_req) check({cur_tag, " opnd_imm"}, int'(opnd_imm), int'(e_imm));
            if (e_valid) begin
                check({cur_tag, " res_acc"}, int'(res_acc), e_acc);
                check({cur_tag, " res_flags"}, int'(res_flags), e_fl);
            end
        end
    end

    // directed single op; checks result at the cycle it must appear
    task automatic one_op(string tag, logic [7:0] op, logic [7:0] a, logic cy,
                          logic [7:0] data, int exp_acc, int exp_fl, bit wait_form);
        cur_tag = tag;
        @(negedge clk);
        op_valid = 1; op_code = op; acc_in = a; cy_in = cy; opnd_data = data;
        @(negedge clk);
        op_valid = 0;
        if (wait_form) begin
            check({tag, " request raised"}, int'(opnd_req), 1);
            check({tag, " no early result"}, int'(res_valid), 0);
            @(negedge clk);
        end
        check({tag, " valid"}, int'(res_valid), 1);
        check({tag, " acc"}, int'(res_acc), exp_acc);
        check({tag, " flags"}, int'(res_flags), exp_fl);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) g[i] = 8'h00;
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        check("R1 reset res_valid", int'(res_valid), 0);
        check("R1 reset opnd_req", int'(opnd_req), 0);
        check("R1 reset flags", int'(res_flags), 0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset res_valid", int'(res_valid), 0);
        check("R1 after reset acc", int'(res_acc), 0);

        g[0] = 8'h01; g[1] = 8'h10; g[2] = 8'h0F; g[3] = 8'h3C; g[4] = 8'h80; g[5] = 8'hFF;
        // SBC A,A corner cases (R3 R4 R5)
        one_op("R3 sbc a,a cy1", 8'h9F, 8'h42, 1'b1, 8'h00, 8'hFF, 8'h70, 0);
        one_op("R5 sbc a,a cy0", 8'h9F, 8'h42, 1'b0, 8'h00, 8'h00, 8'hC0, 0);
        // nibble borrow only: 0x10 - B(0x01) -> 0x0F, H set
        one_op("R4 half borrow", 8'h98, 8'h10, 1'b0, 8'h00, 8'h0F, 8'h60, 0);
        // carry-in only creates borrows: 0x00 - C(0x10)... use E: 0x3C-0x3C-1
        one_op("R2 wrap", 8'h9B, 8'h3C, 1'b1, 8'h00, 8'hFF, 8'h70, 0);
        one_op("R6 xor zero", 8'hAD, 8'hFF, 1'b1, 8'h00, 8'h00, 8'h80, 0);
        one_op("R6 xor value", 8'hAB, 8'h0F, 1'b1, 8'h00, 8'h33, 8'h00, 0);
        one_op("R7 sbc h", 8'h9C, 8'h81, 1'b0, 8'h00, 8'h01, 8'h40, 0);
        one_op("R8 sbc imm", 8'hDE, 8'h20, 1'b1, 8'h05, 8'h1A, 8'h60, 1);
        one_op("R8 xor imm", 8'hEE, 8'h5A, 1'b0, 8'h5A, 8'h00, 8'h80, 1);
        one_op("R9 sbc mem", 8'h9E, 8'h00, 1'b0, 8'h01, 8'hFF, 8'h70, 1);
        one_op("R9 xor mem", 8'hAE, 8'hF0, 1'b0, 8'h0F, 8'hFF, 8'h00, 1);

        // R11: op held through wait cycle with A/carry changing
        cur_tag = "R11";
        @(negedge clk);
        op_valid = 1; op_code = 8'hDE; acc_in = 8'h10; cy_in = 0; opnd_data = 8'h01;
        @(negedge clk);
        op_code = 8'h98; acc_in = 8'h99; cy_in = 1;
        @(negedge clk);
        op_valid = 0;
        check("R11 captured A used", int'(res_acc), 8'h0F);
        check("R11 captured carry used", int'(res_flags), 8'h60);
        @(negedge clk);
        check("R11 held op ignored", int'(res_valid), 0);

        // R12: undefined opcodes
        cur_tag = "R12";
        @(negedge clk);
        op_valid = 1; op_code = 8'h90;
        @(negedge clk);
        op_code = 8'hB0;
        check("R12 no result", int'(res_valid), 0);
        @(negedge clk);
        op_valid = 0;
        check("R12 no request", int'(opnd_req), 0);

        // R13: back-to-back register forms
        cur_tag = "R13";
        @(negedge clk);
        op_valid = 1; op_code = 8'hA8; acc_in = 8'h03; cy_in = 0;
        @(negedge clk);
        check("R13 first", int'(res_acc), 8'h02);
        op_code = 8'h99; acc_in = 8'h20; cy_in = 0;
        @(negedge clk);
        op_valid = 0;
        check("R13 second valid", int'(res_valid), 1);
        check("R13 second acc", int'(res_acc), 8'h10);

        // R7 R10: mixed stream vs model
        cur_tag = "R7 R10 stream";
        for (int k = 0; k < 3000; k++) begin
            int r;
            @(negedge clk);
            r = $urandom % 20;
            if (r < 8) op_code = 8'h98 + 8'(r);
            else if (r < 16) op_code = 8'hA8 + 8'(r - 8);
            else if (r == 16) op_code = 8'hDE;
            else if (r == 17) op_code = 8'hEE;
            else if (r == 18) op_code = 8'($urandom);
            else op_code = 8'h9F;
            op_valid = ($urandom % 4) != 0;
            acc_in = 8'($urandom); cy_in = 1'($urandom);
            opnd_data = 8'($urandom);
            for (int i = 0; i < 6; i++) g[i] = 8'($urandom);
        end
        @(negedge clk);
        op_valid = 0;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule